// File: doc/BRIEF.md
# Sequenced Palette Lookup Table

This block holds a 256-entry colour table, each entry an 8-bit red, green and blue triple, and turns an 8-bit pixel index into its colour. A bus master fills the table through a small 32-bit write window with two registers. The pointer register selects an entry. The colour register takes that entry's components one write at a time, in the order red, green, blue. After the blue write the pointer moves on by one, so a run of colour writes loads consecutive entries with no further pointer writes.

Every component value, and the pointer value, comes from the top byte of the 32-bit write data. The lower three bytes are discarded. The window is write-only: a read returns zero. A separate lookup port registers the colour of the presented index and shows it one cycle later. If the lookup hits an entry in the same cycle that entry is written, the lookup shows the contents before the write.

Top module: `pal_dac`

## Requirements
- R1: After reset every entry reads as 0x000000 (black), except entry 255, which reads as 0xFFFFFF (white).
- R2: A full write to offset 0x0 loads the entry pointer from write data bits 31:24.
- R3: Successive full writes to offset 0x4 store red, then green, then blue into the pointed entry, each from write data bits 31:24.
- R4: The blue write advances the pointer by one modulo 256 (255 wraps to 0) and returns the sequence to red.
- R5: A write to offset 0x0 part-way through a sequence restarts it at red.
- R6: Writes to any offset other than 0x0 and 0x4 change neither the pointer, the sequence position, nor any entry.
- R7: A write whose byte enables are not all four set (be != 4'hF) is ignored.
- R8: Read data on the bus window is always zero.
- R9: The lookup outputs show the entry selected by the pixel index one clock after that index is presented (red on bits 23:16 of the expected triple, green on 15:8, blue on 7:0).
- R10: A lookup of an entry in the same cycle that entry is written returns the value from before the write.
- R11: Write data bits 23:0 have no effect on any stored value or on the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe for the register window |
| bus_be_i | input | 4 | Byte enables; only 4'hF is accepted |
| bus_addr_i | input | 4 | Byte offset within the 16-byte window |
| bus_wdata_i | input | 32 | Write data; value in bits 31:24 |
| bus_rdata_o | output | 32 | Read data, always zero |
| pix_idx_i | input | 8 | Lookup index |
| pix_r_o | output | 8 | Red component of the looked-up entry |
| pix_g_o | output | 8 | Green component of the looked-up entry |
| pix_b_o | output | 8 | Blue component of the looked-up entry |

## Verification
The hardest case to reach is a collision, where the lookup reads an entry in the very cycle its blue component is written. The bench loads red and green for one entry and presents that entry's index on the lookup port. It then drives the blue write and the same index together on one falling edge. It checks the partial old value one cycle later and the complete value the cycle after. The pointer wrap from 255 to 0 and the restart of a sequence half-way through are reached by pointer writes placed just before the colour writes.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int unsigned NUM_COMP = 3;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;

  localparam logic [3:0] OFF_PTR = 4'h0;
  localparam logic [3:0] OFF_COL = 4'h4;
endpackage

// File: rtl/pal_seq.sv
module pal_seq
  import pal_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [DATA_W/8-1:0]   be_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic                  wr_o,
  output logic [IDX_W-1:0]      wr_idx_o,
  output phase_e                wr_sel_o,
  output logic [COMP_W-1:0]     wr_val_o
);
  localparam int unsigned LOW_W = DATA_W - COMP_W;

  logic            full_w;
  logic            ptr_hit, col_hit;
  logic [IDX_W-1:0] idx_q;
  phase_e           ph_q;
  logic             unused_low;

  assign full_w  = &be_i;
  assign ptr_hit = we_i && full_w && (addr_i == ADDR_W'(OFF_PTR));
  assign col_hit = we_i && full_w && (addr_i == ADDR_W'(OFF_COL));
  assign unused_low = ^wdata_i[LOW_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      ph_q  <= PH_RED;
    end else if (ptr_hit) begin
      idx_q <= wdata_i[DATA_W-1 -: IDX_W];
      ph_q  <= PH_RED;
    end else if (col_hit) begin
      unique case (ph_q)
        PH_RED:  ph_q <= PH_GRN;
        PH_GRN:  ph_q <= PH_BLU;
        default: begin
          ph_q  <= PH_RED;
          idx_q <= idx_q + 1'b1;
        end
      endcase
    end
  end

  assign wr_o     = col_hit;
  assign wr_idx_o = idx_q;
  assign wr_sel_o = ph_q;
  assign wr_val_o = wdata_i[DATA_W-1 -: COMP_W];

  AST_PTR_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_hit |=> (ph_q == PH_RED && idx_q == $past(wdata_i[DATA_W-1 -: IDX_W]))); // R5
  AST_IDX_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_hit && ph_q == PH_BLU) |=> (idx_q == IDX_W'($past(idx_q) + 1'b1) && ph_q == PH_RED)); // R4
  AST_IGNORED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ptr_hit && !col_hit) |=> ($stable(idx_q) && $stable(ph_q))); // R6
  AST_PARTIAL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !full_w) |=> ($stable(idx_q) && $stable(ph_q))); // R7
  AST_PHASE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q != 2'd3); // R3
endmodule

// File: rtl/pal_mem.sv
module pal_mem
  import pal_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  logic [IDX_W-1:0]           wr_idx_i,
  input  phase_e                     wr_sel_i,
  input  logic [COMP_W-1:0]          wr_val_i,
  input  logic [IDX_W-1:0]           rd_idx_i,
  output logic [NUM_COMP*COMP_W-1:0] rd_rgb_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [NUM_COMP-1:0] wr_en;

  for (genvar c = 0; c < NUM_COMP; c++) begin : g_comp
    logic [COMP_W-1:0] tbl_q [DEPTH];
    logic [COMP_W-1:0] rd_q;

    assign wr_en[c] = wr_i && (wr_sel_i == phase_e'(c));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int e = 0; e < DEPTH; e++) begin
          tbl_q[e] <= (e == DEPTH - 1) ? '1 : '0;
        end
      end else if (wr_en[c]) begin
        tbl_q[wr_idx_i] <= wr_val_i;
      end
    end

    // read sees pre-write contents on a collision
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rd_q <= '0;
      else         rd_q <= tbl_q[rd_idx_i];
    end

    assign rd_rgb_o[(NUM_COMP-1-c)*COMP_W +: COMP_W] = rd_q;
  end

  AST_ONE_COMP_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_en)); // R3
  AST_WR_ONLY_ON_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |-> (wr_en == '0)); // R6
endmodule

// File: rtl/pal_dac.sv
module pal_dac
  import pal_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_we_i,
  input  logic [DATA_W/8-1:0] bus_be_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  output logic [DATA_W-1:0]   bus_rdata_o,
  input  logic [IDX_W-1:0]    pix_idx_i,
  output logic [COMP_W-1:0]   pix_r_o,
  output logic [COMP_W-1:0]   pix_g_o,
  output logic [COMP_W-1:0]   pix_b_o
);
  logic              mem_wr;
  logic [IDX_W-1:0]  mem_idx;
  phase_e            mem_sel;
  logic [COMP_W-1:0] mem_val;
  logic [NUM_COMP*COMP_W-1:0] rgb;

  pal_seq #(
    .IDX_W(IDX_W), .COMP_W(COMP_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (bus_we_i),
    .be_i     (bus_be_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .wr_o     (mem_wr),
    .wr_idx_o (mem_idx),
    .wr_sel_o (mem_sel),
    .wr_val_o (mem_val)
  );

  pal_mem #(
    .IDX_W(IDX_W), .COMP_W(COMP_W)
  ) u_mem (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (mem_wr),
    .wr_idx_i (mem_idx),
    .wr_sel_i (mem_sel),
    .wr_val_i (mem_val),
    .rd_idx_i (pix_idx_i),
    .rd_rgb_o (rgb)
  );

  assign bus_rdata_o = '0;
  assign pix_r_o = rgb[3*COMP_W-1 -: COMP_W];
  assign pix_g_o = rgb[2*COMP_W-1 -: COMP_W];
  assign pix_b_o = rgb[COMP_W-1   -: COMP_W];

  AST_WR_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr |-> (bus_we_i && bus_be_i == '1 && bus_addr_i == ADDR_W'(OFF_COL))); // R7
endmodule

// File: tb/tb_pal_dac.sv
`timescale 1ns/1ps
module tb_pal_dac;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  be = 4'h0;
  logic [3:0]  addr = 4'h0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  pidx = '0;
  logic [7:0]  pr, pg, pb;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pal_dac dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_be_i(be),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pix_idx_i(pidx), .pix_r_o(pr), .pix_g_o(pg), .pix_b_o(pb)
  );

  task automatic expect24(string tag, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%06h expected=%06h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d, logic [3:0] b = 4'hF);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d; be = b;
    @(negedge clk);
    we = 1'b0; be = 4'h0;
  endtask

  task automatic look(string tag, logic [7:0] idx, logic [23:0] exp);
    @(negedge clk);
    pidx = idx;
    @(negedge clk);
    expect24(tag, {pr, pg, pb}, exp);
  endtask

  task automatic t_reset();
    look("R1 entry0", 8'd0, 24'h000000);
    look("R1 entry128", 8'd128, 24'h000000);
    look("R1 entry254", 8'd254, 24'h000000);
    look("R1 entry255", 8'd255, 24'hFFFFFF);
  endtask

  task automatic t_basic();
    wr(4'h0, 32'h05ABCDEF);
    wr(4'h4, 32'h11FFFFFF);
    checks++;
    if (rdata !== 32'h0) begin
      errors++;
      $display("FAIL R8 actual=%08h expected=00000000", rdata);
    end
    wr(4'h4, 32'h22000001);
    wr(4'h4, 32'h33123456);
    look("R2 R3 R11 entry5", 8'd5, 24'h112233);
    wr(4'h4, 32'h44000000);
    wr(4'h4, 32'h55000000);
    wr(4'h4, 32'h66000000);
    look("R4 R9 entry6", 8'd6, 24'h445566);
    look("R4 entry5 kept", 8'd5, 24'h112233);
  endtask

  task automatic t_wrap();
    wr(4'h0, 32'hFF000000);
    wr(4'h4, 32'h01000000);
    wr(4'h4, 32'h02000000);
    wr(4'h4, 32'h03000000);
    wr(4'h4, 32'h0A000000);
    wr(4'h4, 32'h0B000000);
    wr(4'h4, 32'h0C000000);
    look("R4 entry255", 8'd255, 24'h010203);
    look("R4 wrap entry0", 8'd0, 24'h0A0B0C);
  endtask

  task automatic t_restart();
    wr(4'h0, 32'h20000000);
    wr(4'h4, 32'h77000000);
    wr(4'h0, 32'h20000000);
    wr(4'h4, 32'h88000000);
    wr(4'h4, 32'h99000000);
    wr(4'h4, 32'hAA000000);
    look("R5 entry32", 8'h20, 24'h8899AA);
    look("R5 entry33 untouched", 8'h21, 24'h000000);
  endtask

  task automatic t_ignored();
    wr(4'h0, 32'h30000000);
    wr(4'h8, 32'h50000000);
    wr(4'hC, 32'h51000000);
    wr(4'h5, 32'h52000000);
    look("R6 entry48 after stray", 8'h30, 24'h000000);
    wr(4'h4, 32'h53000000, 4'h3);
    wr(4'h4, 32'h54000000, 4'h8);
    wr(4'h0, 32'h70000000, 4'h7);
    look("R7 entry48 after partial", 8'h30, 24'h000000);
    wr(4'h4, 32'h01000000);
    wr(4'h4, 32'h02000000);
    wr(4'h4, 32'h03000000);
    look("R6 R7 sequence intact", 8'h30, 24'h010203);
    look("R7 entry112 untouched", 8'h70, 24'h000000);
  endtask

  task automatic t_collide();
    wr(4'h0, 32'h40000000);
    wr(4'h4, 32'hC1000000);
    wr(4'h4, 32'hC2000000);
    look("R10 before", 8'h40, 24'hC1C200);
    @(negedge clk);
    we = 1'b1; addr = 4'h4; wdata = 32'hC3000000; be = 4'hF;
    pidx = 8'h40;
    @(negedge clk);
    we = 1'b0; be = 4'h0;
    expect24("R10 old value on collision", {pr, pg, pb}, 24'hC1C200);
    @(negedge clk);
    expect24("R10 new value after", {pr, pg, pb}, 24'hC1C2C3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_wrap();
    t_restart();
    t_ignored();
    t_collide();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule